// File: doc/BRIEF.md
# Controller Sleep/Wake Mailbox Responder

This block is the target side of a byte-wide index/data mailbox through which a host asks an embedded controller to stop using, or to resume using, a bus the two of them share. The host first selects a mailbox register by writing its number to the index port. It then reads or writes that register through the data port. A request is always the same three writes. The host clears the status register, places a command code in the command register, and writes a fixed key value into the trigger register.

When the key arrives with a recognised command and no other request is in flight, the responder latches the request and waits a programmable number of clock cycles. It then writes a fixed acknowledge code into the status register and updates its sleep flag. The host polls the status register until the acknowledge code shows up. The host allows roughly half a second in total, so the latency parameter must stay far below that figure at the chosen clock. A request with a wrong key or an unknown command is dropped without any trace.

Top module: `ec_sleep_mailbox`

## Requirements
- R1: `portSel` = 0 addresses the index port and `portSel` = 1 addresses the data port. A write to the index port selects the mailbox register. `rdData` returns the index value when `portSel` = 0, and returns the selected register when `portSel` = 1.
- R2: Register 0x82 (status) accepts any host write and reads the written value back until the responder acknowledges.
- R3: Register 0x83 (command) holds the last byte written to it and reads it back.
- R4: Writing 0x96 to register 0x80 (trigger) while the command register holds 0xB4 or 0xB5 and no request is in flight starts a request. Status reads 0xFA exactly `ACK_LATENCY` cycles after the clock edge that took the trigger write. Before that cycle, status keeps its previous value (0x00 after a clear).
- R5: `sleepActive` rises when an acknowledge for 0xB4 (sleep) lands and falls when an acknowledge for 0xB5 (wake) lands. It changes in the same cycle that status becomes 0xFA.
- R6: A trigger write of any value other than 0x96, or a trigger write with a command other than 0xB4 or 0xB5, produces no acknowledge and leaves `sleepActive` unchanged.
- R7: A wake request while awake, or a sleep request while asleep, is still acknowledged with 0xFA and leaves `sleepActive` as it was.
- R8: The command is latched at the trigger. A trigger write while a request is in flight is ignored, and a command register write during the wait does not alter the outcome.
- R9: Registers other than 0x80, 0x82 and 0x83 ignore writes and read as 0x00.
- R10: After reset, the index, status, command and trigger registers are 0x00 and `sleepActive` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| portSel | input | 1 | 0 = index port, 1 = data port |
| wrEn | input | 1 | Write strobe for the addressed port |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the addressed port (combinational) |
| sleepActive | output | 1 | High while the controller is told to keep off the shared bus |

## Verification
The bench times the acknowledge to the exact cycle: status must still read 0x00 one cycle before the latency expires and 0xFA on the cycle it does. A counter that is off by one would show the code early or late. It sends a near-miss key (0x95) and an unknown command (0xB6); a decoder that looked at too few bits would acknowledge them. It also re-triggers with a changed command while a request is in flight. A design that restarted the timer or read the live command register would then post a second acknowledge or wake the controller. A repeated wake checks that acknowledge and flag are separate effects, and a reference model compares read data and `sleepActive` on every cycle.

// File: rtl/ec_mbx_pkg.sv
package ec_mbx_pkg;
  parameter int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] REG_TRIGGER = 8'h80;
  localparam logic [BYTE_W-1:0] REG_STATUS  = 8'h82;
  localparam logic [BYTE_W-1:0] REG_COMMAND = 8'h83;
  localparam logic [BYTE_W-1:0] KEY_GO      = 8'h96;
  localparam logic [BYTE_W-1:0] CMD_SLEEP   = 8'hB4;
  localparam logic [BYTE_W-1:0] CMD_WAKE    = 8'hB5;
  localparam logic [BYTE_W-1:0] ACK_CODE    = 8'hFA;

  typedef struct packed {
    logic loadIndex;
    logic loadStatus;
    logic loadCmd;
    logic loadTrig;
    logic ackDone;
    logic ackSleep;
  } mbxStrobe_t;
endpackage

// File: rtl/ec_mbx_ctrl.sv
module ec_mbx_ctrl
  import ec_mbx_pkg::*;
#(
  parameter int ACK_LATENCY = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              portSel,
  input  logic              wrEn,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [BYTE_W-1:0] idxByte,
  input  logic [BYTE_W-1:0] cmdByte,
  output mbxStrobe_t        strobe,
  output logic              busy
);
  localparam int CNT_W = (ACK_LATENCY > 1) ? $clog2(ACK_LATENCY) : 1;

  logic [CNT_W-1:0] waitCnt;
  logic             pendSleep;
  logic             dataWr;
  logic             cmdKnown;
  logic             startReq;

  always_comb begin
    dataWr            = wrEn && portSel;
    cmdKnown          = (cmdByte == CMD_SLEEP) || (cmdByte == CMD_WAKE);
    strobe.loadIndex  = wrEn && !portSel;
    strobe.loadStatus = dataWr && (idxByte == REG_STATUS);
    strobe.loadCmd    = dataWr && (idxByte == REG_COMMAND);
    strobe.loadTrig   = dataWr && (idxByte == REG_TRIGGER);
    strobe.ackDone    = busy && (waitCnt == '0);
    strobe.ackSleep   = pendSleep;
    startReq          = strobe.loadTrig && (wrData == KEY_GO) && !busy && cmdKnown;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      waitCnt   <= '0;
      pendSleep <= 1'b0;
    end else if (startReq) begin
      busy      <= 1'b1;
      waitCnt   <= CNT_W'(ACK_LATENCY - 1);
      pendSleep <= (cmdByte == CMD_SLEEP);
    end else if (busy) begin
      if (waitCnt == '0) busy <= 1'b0;
      else               waitCnt <= waitCnt - 1'b1;
    end
  end
endmodule

// File: rtl/ec_mbx_datapath.sv
module ec_mbx_datapath
  import ec_mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              portSel,
  input  logic [BYTE_W-1:0] wrData,
  input  mbxStrobe_t        strobe,
  output logic [BYTE_W-1:0] idxByte,
  output logic [BYTE_W-1:0] cmdByte,
  output logic [BYTE_W-1:0] statusByte,
  output logic [BYTE_W-1:0] rdData,
  output logic              sleepActive
);
  logic [BYTE_W-1:0] trigByte;
  logic [BYTE_W-1:0] regView;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxByte     <= '0;
      cmdByte     <= '0;
      trigByte    <= '0;
      statusByte  <= '0;
      sleepActive <= 1'b0;
    end else begin
      if (strobe.loadIndex) idxByte  <= wrData;
      if (strobe.loadCmd)   cmdByte  <= wrData;
      if (strobe.loadTrig)  trigByte <= wrData;
      if (strobe.ackDone) begin
        statusByte  <= ACK_CODE;
        sleepActive <= strobe.ackSleep;
      end else if (strobe.loadStatus) begin
        statusByte <= wrData;
      end
    end
  end

  always_comb begin
    case (idxByte)
      REG_TRIGGER: regView = trigByte;
      REG_STATUS:  regView = statusByte;
      REG_COMMAND: regView = cmdByte;
      default:     regView = '0;
    endcase
    rdData = portSel ? regView : idxByte;
  end
endmodule

// File: rtl/ec_sleep_mailbox.sv
module ec_sleep_mailbox
  import ec_mbx_pkg::*;
#(
  parameter int ACK_LATENCY = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              portSel,
  input  logic              wrEn,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdData,
  output logic              sleepActive
);
  mbxStrobe_t        strobe;
  logic              busyFlag;
  logic [BYTE_W-1:0] idxByte;
  logic [BYTE_W-1:0] cmdByte;
  logic [BYTE_W-1:0] statusByte;

  ec_mbx_ctrl #(.ACK_LATENCY(ACK_LATENCY)) u_ctrl (
    .clk(clk), .rstN(rstN), .portSel(portSel), .wrEn(wrEn), .wrData(wrData),
    .idxByte(idxByte), .cmdByte(cmdByte), .strobe(strobe), .busy(busyFlag)
  );

  ec_mbx_datapath u_dp (
    .clk(clk), .rstN(rstN), .portSel(portSel), .wrData(wrData), .strobe(strobe),
    .idxByte(idxByte), .cmdByte(cmdByte), .statusByte(statusByte),
    .rdData(rdData), .sleepActive(sleepActive)
  );
endmodule

// File: rtl/ec_sleep_mailbox_chk.sv
module ec_sleep_mailbox_chk
  import ec_mbx_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              portSel,
  input logic              wrEn,
  input logic [BYTE_W-1:0] wrData,
  input logic [BYTE_W-1:0] idxByte,
  input logic [BYTE_W-1:0] cmdByte,
  input logic [BYTE_W-1:0] statusByte,
  input logic              busyFlag,
  input logic              sleepActive
);
  logic trigWr;
  assign trigWr = wrEn && portSel && (idxByte == REG_TRIGGER);

  AST_SLEEP_MOVES_WITH_ACK: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sleepActive) |-> (statusByte == ACK_CODE)); // R5

  AST_WAIT_ENDS_WITH_ACK: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyFlag) |-> (statusByte == ACK_CODE)); // R4

  AST_GOOD_KEY_STARTS: assert property (@(posedge clk) disable iff (!rstN)
    (trigWr && wrData == KEY_GO && !busyFlag &&
     (cmdByte == CMD_SLEEP || cmdByte == CMD_WAKE)) |=> busyFlag); // R4

  AST_BAD_KEY_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    (trigWr && wrData != KEY_GO && !busyFlag) |=> !busyFlag); // R6

  AST_BAD_CMD_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    (trigWr && !busyFlag && cmdByte != CMD_SLEEP && cmdByte != CMD_WAKE) |=> !busyFlag); // R6
endmodule

bind ec_sleep_mailbox ec_sleep_mailbox_chk u_chk (
  .clk(clk), .rstN(rstN), .portSel(portSel), .wrEn(wrEn), .wrData(wrData),
  .idxByte(idxByte), .cmdByte(cmdByte), .statusByte(statusByte),
  .busyFlag(busyFlag), .sleepActive(sleepActive)
);

// File: tb/ec_sleep_mailbox_bench.sv
module ec_sleep_mailbox_bench;
  localparam int LAT = 12;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       portSel = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       sleepActive;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ec_sleep_mailbox #(.ACK_LATENCY(LAT)) u_ec_sleep_mailbox (
    .clk(clk), .rstN(rstN), .portSel(portSel), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .sleepActive(sleepActive)
  );

  // Behavioural reference model
  int mIdx, mStat, mCmd, mTrig, mSleep, mBusy, mLeft, mPend;

  always @(posedge clk) begin
    if (!rstN) begin
      mIdx = 0; mStat = 0; mCmd = 0; mTrig = 0;
      mSleep = 0; mBusy = 0; mLeft = 0; mPend = 0;
    end else begin
      int wasBusy;
      int ackNow;
      wasBusy = mBusy;
      ackNow  = 0;
      if (mBusy) begin
        mLeft = mLeft - 1;
        if (mLeft == 0) begin
          ackNow = 1;
          mBusy  = 0;
        end
      end
      if (wrEn && !portSel) mIdx = wrData;
      else if (wrEn) begin
        if (mIdx == 'h82) mStat = wrData;
        else if (mIdx == 'h83) mCmd = wrData;
        else if (mIdx == 'h80) begin
          mTrig = wrData;
          if (wrData == 8'h96 && !wasBusy && (mCmd == 'hB4 || mCmd == 'hB5)) begin
            mBusy = 1;
            mLeft = LAT;
            mPend = (mCmd == 'hB4);
          end
        end
      end
      if (ackNow) begin
        mStat  = 'hFA;
        mSleep = mPend;
      end
    end
  end

  function automatic int modelRead(logic sel);
    if (!sel) return mIdx;
    if (mIdx == 'h80) return mTrig;
    if (mIdx == 'h82) return mStat;
    if (mIdx == 'h83) return mCmd;
    return 0;
  endfunction

  always @(negedge clk) begin
    #2;
    if (rstN && !done) begin
      tests++;
      if (int'(rdData) != modelRead(portSel)) begin
        fails++;
        $display("FAIL R1 model read sel=%0d: got %h exp %h", portSel, rdData, modelRead(portSel));
      end
      tests++;
      if (int'(sleepActive) != mSleep) begin
        fails++;
        $display("FAIL R5 model sleepActive: got %0d exp %0d", sleepActive, mSleep);
      end
    end
  end

  task automatic chk(string tag, int got, int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %h exp %h", tag, got, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge after the write edge
  task automatic wr(logic sel, logic [7:0] d);
    portSel = sel; wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(logic sel, output int v);
    portSel = sel;
    #1;
    v = rdData;
  endtask

  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    rd(0, v); chk("R10 index after reset", v, 'h00);
    chk("R10 sleepActive after reset", sleepActive, 0);
    wr(0, 8'h82); rd(1, v); chk("R10 status after reset", v, 'h00);
    wr(0, 8'h83); rd(1, v); chk("R10 command after reset", v, 'h00);

    wr(0, 8'h81); wr(1, 8'h55); rd(1, v); chk("R9 unmapped reads zero", v, 'h00);
    rd(0, v); chk("R1 index readback", v, 'h81);

    wr(0, 8'h83); wr(1, 8'hB4); rd(1, v); chk("R3 command readback", v, 'hB4);
    wr(0, 8'h82); wr(1, 8'h3C); rd(1, v); chk("R2 status readback", v, 'h3C);
    wr(1, 8'h00); rd(1, v); chk("R2 status cleared", v, 'h00);

    // sleep request: trigger edge T
    wr(0, 8'h80); wr(1, 8'h96);
    wr(0, 8'h82);                 // after T+1
    waitN(LAT - 2);               // after T+LAT-1
    rd(1, v); chk("R4 no ack before latency", v, 'h00);
    chk("R5 sleep not yet set", sleepActive, 0);
    waitN(1);                     // after T+LAT
    rd(1, v); chk("R4 ack at latency", v, 'hFA);
    chk("R5 sleep set on ack", sleepActive, 1);

    // wake request
    wr(1, 8'h00);
    wr(0, 8'h83); wr(1, 8'hB5);
    wr(0, 8'h80); wr(1, 8'h96);   // after T
    waitN(LAT - 1);
    chk("R5 still asleep before wake ack", sleepActive, 1);
    waitN(1);
    chk("R5 wake clears sleep", sleepActive, 0);
    wr(0, 8'h82); rd(1, v); chk("R4 wake acknowledged", v, 'hFA);

    // repeated wake while awake
    wr(1, 8'h00);
    wr(0, 8'h80); wr(1, 8'h96);
    waitN(LAT + 1);
    chk("R7 repeated wake keeps awake", sleepActive, 0);
    wr(0, 8'h82); rd(1, v); chk("R7 repeated wake acknowledged", v, 'hFA);

    // near-miss key
    wr(1, 8'h00);
    wr(0, 8'h83); wr(1, 8'hB4);
    wr(0, 8'h80); wr(1, 8'h95);
    rd(1, v); chk("R6 trigger register holds bad key", v, 'h95);
    waitN(LAT + 2);
    chk("R6 bad key leaves sleep", sleepActive, 0);
    wr(0, 8'h82); rd(1, v); chk("R6 bad key no ack", v, 'h00);

    // unknown command
    wr(0, 8'h83); wr(1, 8'hB6);
    wr(0, 8'h80); wr(1, 8'h96);
    waitN(LAT + 2);
    chk("R6 unknown command leaves sleep", sleepActive, 0);
    wr(0, 8'h82); rd(1, v); chk("R6 unknown command no ack", v, 'h00);

    // re-trigger with changed command while in flight
    wr(0, 8'h83); wr(1, 8'hB4);
    wr(0, 8'h80); wr(1, 8'h96);   // after T
    wr(0, 8'h83); wr(1, 8'hB5);   // after T+2
    wr(0, 8'h80); wr(1, 8'h96);   // after T+4, ignored
    wr(0, 8'h82);                 // after T+5
    waitN(LAT - 5);               // after T+LAT
    chk("R8 latched sleep command applied", sleepActive, 1);
    rd(1, v); chk("R8 first ack", v, 'hFA);
    wr(1, 8'h00);
    waitN(8);
    rd(1, v); chk("R8 no second ack", v, 'h00);
    chk("R8 retrigger did not wake", sleepActive, 1);

    // sleep while asleep
    wr(0, 8'h83); wr(1, 8'hB4);
    wr(0, 8'h80); wr(1, 8'h96);
    waitN(LAT + 1);
    chk("R7 repeated sleep keeps asleep", sleepActive, 1);
    wr(0, 8'h82); rd(1, v); chk("R7 repeated sleep acknowledged", v, 'hFA);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule